// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the pixel and line counters, the active-video enable, the horizontal and vertical sync pulses and a once-per-line early-fetch strobe for a progressive-scan raster display. A host programs the line and frame geometry through a small write-only register bus running in the pixel clock domain. Every geometric bound is written as an inclusive end count, so a value of N describes N+1 pixels or lines.

A sync-shaping stage sits after the counters. It can invert either sync, silence either sync alone, silence both at once, and drive a composite sync-on-RGB signal. A separate blanking control suppresses active video while the syncs keep running, which lets a monitor stay locked during a blank. Geometry writes made while the generator runs are held in shadow storage and applied together at the next frame start. Control, sync-shaping and blanking writes act on the next cycle.

Top module: `dtg_top`

## Requirements
- R1: While running, the pixel counter steps 0,1,...,`h_total` and then returns to 0. The line counter advances by one only on that pixel wrap, and it returns to 0 after reaching `v_total`.
- R2: `de` is high when the pixel count is ≤ `h_active`, the line count is ≤ `v_active`, control bits 0 and 1 are both set and display-control bit 2 is clear.
- R3: The raw horizontal sync is active for pixel counts c with `hs_start` < c ≤ `hs_end`. The raw vertical sync is active for line counts with `vs_start` < c ≤ `vs_end`.
- R4: `fetch` pulses high for exactly the one cycle in each line whose pixel count equals the fetch-point register.
- R5: With control bit 0 clear, both counters hold at 0, `de`, `fetch` and `rgb_sync` are low, and each sync output sits at its inactive level (its inversion bit). This is also the state after reset.
- R6: With control bit 0 set and bit 1 clear, the counters and syncs run normally but `de` stays low.
- R7: Sync-control bit 3 inverts `hsync` and bit 4 inverts `vsync`.
- R8: Sync-control bit 5 silences the horizontal sync, bit 6 silences the vertical sync, and bit 1 silences both. A silenced sync output holds its inactive level.
- R9: With sync-control bit 0 set, `rgb_sync` is high whenever either sync is active after silencing (before inversion). With bit 0 clear, `rgb_sync` is low.
- R10: Display-control bit 2 forces `de` low while the counters and syncs keep running.
- R11: Geometry writes made while running take effect from the first cycle of the next frame (pixel 0, line 0). While the generator is stopped, they take effect on the next cycle. Control, sync-control and display-control writes take effect on the next cycle.
- R12: A write with `wr_en` high loads the register at `wr_addr`: 0 control, 1 sync control, 2 display control, 3 `h_total`, 4 `h_active`, 5 `hs_start`, 6 `hs_end`, 7 `v_total`, 8 `v_active`, 9 `vs_start`, 10 `vs_end`, 11 fetch point. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index |
| wr_data | input | CW | Write data |
| hcount | output | CW | Pixel counter within the line |
| vcount | output | CW | Line counter within the frame |
| de | output | 1 | Active-video enable |
| hsync | output | 1 | Horizontal sync after shaping |
| vsync | output | 1 | Vertical sync after shaping |
| rgb_sync | output | 1 | Composite sync for sync-on-RGB |
| fetch | output | 1 | Early-fetch strobe, once per line |

## Verification
The assertions assume a coherent geometry: every horizontal bound is at or below `h_total`, every vertical bound is at or below `v_total`, and the fetch point lies inside the line. Under that assumption the fetch strobe can never fire twice in a row and the counters never run past their extents. The stimulus programs one small geometry of 12 pixels by 8 lines with all bounds inside it while the generator is stopped. The only mid-run geometry write is a smaller active width, which keeps every bound legal across the frame-start switch.

// File: rtl/dtg_pkg.sv
// Package dtg_pkg: register indices, control bit positions and the
// sync-shaping configuration type shared by the timing generator modules.
package dtg_pkg;

    // Register indices on the write bus (R12)
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_SYNC     = 1;
    localparam int ADDR_DISP     = 2;
    localparam int ADDR_TIM_BASE = 3;

    // Index of each geometry register inside the timing bank
    localparam int TIM_HTOT  = 0;
    localparam int TIM_HACT  = 1;
    localparam int TIM_HSS   = 2;
    localparam int TIM_HSE   = 3;
    localparam int TIM_VTOT  = 4;
    localparam int TIM_VACT  = 5;
    localparam int TIM_VSS   = 6;
    localparam int TIM_VSE   = 7;
    localparam int TIM_FETCH = 8;
    localparam int NUM_TIM   = 9;

    // Control register bits
    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_REFRESH_BIT = 1;

    // Sync-control register bits
    localparam int SYNC_RGB_BIT   = 0;
    localparam int SYNC_ALL_BIT   = 1;
    localparam int SYNC_HINV_BIT  = 3;
    localparam int SYNC_VINV_BIT  = 4;
    localparam int SYNC_HOFF_BIT  = 5;
    localparam int SYNC_VOFF_BIT  = 6;

    // Display-control bit
    localparam int DISP_BLANK_BIT = 2;

    typedef struct packed {
        logic rgb;
        logic all_off;
        logic h_inv;
        logic v_inv;
        logic h_off;
        logic v_off;
    } sync_cfg_t;

endpackage

// File: rtl/dtg_regs.sv
// Module dtg_regs: host-writable register bank. Geometry registers
// have a shadow copy that is written at any time and an active copy
// that reloads while stopped or on the frame-start cycle. Control,
// sync and blank settings act directly.
// Assumes: wr_data is at least 7 bits wide.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [CW-1:0]                wr_data,
    input  logic                         frame_start,
    output logic                         run,
    output logic                         refresh,
    output logic                         blank,
    output sync_cfg_t                    sync_cfg,
    output logic [NUM_TIM-1:0][CW-1:0]   tim
);

    logic [NUM_TIM-1:0][CW-1:0] shadow;

    // Capture control, sync-shaping and blanking writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            refresh  <= 1'b0;
            blank    <= 1'b0;
            sync_cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_CTRL)) begin
                run     <= wr_data[CTRL_RUN_BIT];
                refresh <= wr_data[CTRL_REFRESH_BIT];
            end
            if (wr_addr == AW'(ADDR_SYNC)) begin
                sync_cfg.rgb     <= wr_data[SYNC_RGB_BIT];
                sync_cfg.all_off <= wr_data[SYNC_ALL_BIT];
                sync_cfg.h_inv   <= wr_data[SYNC_HINV_BIT];
                sync_cfg.v_inv   <= wr_data[SYNC_VINV_BIT];
                sync_cfg.h_off   <= wr_data[SYNC_HOFF_BIT];
                sync_cfg.v_off   <= wr_data[SYNC_VOFF_BIT];
            end
            if (wr_addr == AW'(ADDR_DISP))
                blank <= wr_data[DISP_BLANK_BIT];
        end
    end

    // Shadow geometry registers follow host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else begin
            for (int i = 0; i < NUM_TIM; i++)
                if (wr_en && wr_addr == AW'(ADDR_TIM_BASE + i))
                    shadow[i] <= wr_data;
        end
    end

    // Active geometry reloads while stopped or at frame start
    always_ff @(posedge clk) begin
        if (!rst_n)
            tim <= '0;
        else if (!run || frame_start)
            tim <= shadow;
    end

    // R11
    tim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_start) |=> (tim == $past(tim)));

endmodule

// File: rtl/dtg_counters.sv
// Module dtg_counters: pixel and line counters. Pixel count wraps after
// h_total, and each wrap advances the line count, which wraps after
// v_total. Both hold at zero while stopped.
// Assumes: the extents only change on the frame-start cycle.
module dtg_counters #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    output logic [CW-1:0] hcnt,
    output logic [CW-1:0] vcnt,
    output logic          frame_start
);

    logic h_last;
    logic v_last;

    assign h_last      = (hcnt >= htot);
    assign v_last      = (vcnt >= vtot);
    assign frame_start = run && h_last && v_last;

    // Step the raster position one pixel per clock
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // R1
    hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hcnt >= htot) |=> (hcnt == '0));

    // R1
    vhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hcnt < htot) |=> (vcnt == $past(vcnt)));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hcnt == '0 && vcnt == '0));

endmodule

// File: rtl/dtg_sync.sv
// Module dtg_sync: decodes the raster position into active video, raw
// syncs and the fetch strobe, then applies silencing, inversion,
// sync-on-RGB and blanking. Outputs are combinational from the counters.
// Assumes: bounds lie inside the programmed extents.
module dtg_sync
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          refresh,
    input  logic          blank,
    input  sync_cfg_t     cfg,
    input  logic [CW-1:0] hcnt,
    input  logic [CW-1:0] vcnt,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] hact,
    input  logic [CW-1:0] hss,
    input  logic [CW-1:0] hse,
    input  logic [CW-1:0] vact,
    input  logic [CW-1:0] vss,
    input  logic [CW-1:0] vse,
    input  logic [CW-1:0] fetch_pt,
    output logic          de_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          rgb_sync_o,
    output logic          fetch_o
);

    logic hs_raw, vs_raw, hs_live, vs_live;

    // Decode raw syncs from the raster position
    always_comb begin
        hs_raw = run && (hcnt > hss) && (hcnt <= hse);
        vs_raw = run && (vcnt > vss) && (vcnt <= vse);
    end

    // Silence, invert and combine the syncs
    always_comb begin
        hs_live    = hs_raw && !cfg.all_off && !cfg.h_off;
        vs_live    = vs_raw && !cfg.all_off && !cfg.v_off;
        hsync_o    = hs_live ^ cfg.h_inv;
        vsync_o    = vs_live ^ cfg.v_inv;
        rgb_sync_o = cfg.rgb && (hs_live || vs_live);
    end

    // Active video and the early-fetch strobe
    always_comb begin
        de_o    = run && refresh && !blank && (hcnt <= hact) && (vcnt <= vact);
        fetch_o = run && (hcnt == fetch_pt);
    end

    // R10
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank || !refresh) |-> !de_o);

    // R5
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!de_o && !fetch_o && !rgb_sync_o
                  && hsync_o == cfg.h_inv && vsync_o == cfg.v_inv));

    // R8
    forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.all_off |-> (hsync_o == cfg.h_inv && vsync_o == cfg.v_inv && !rgb_sync_o));

    // R4
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && hcnt < htot) |=> !fetch_o);

endmodule

// File: rtl/dtg_top.sv
// Module dtg_top: programmable raster timing generator. Ties the
// register bank, the raster counters and the sync-shaping stage.
// Assumes: a single pixel clock domain for the host bus and the display.
module dtg_top
    import dtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] hcount,
    output logic [CW-1:0] vcount,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic          rgb_sync,
    output logic          fetch
);

    logic                       run, refresh, blank, frame_start;
    sync_cfg_t                  sync_cfg;
    logic [NUM_TIM-1:0][CW-1:0] tim;

    dtg_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .run         (run),
        .refresh     (refresh),
        .blank       (blank),
        .sync_cfg    (sync_cfg),
        .tim         (tim)
    );

    dtg_counters #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .htot        (tim[TIM_HTOT]),
        .vtot        (tim[TIM_VTOT]),
        .hcnt        (hcount),
        .vcnt        (vcount),
        .frame_start (frame_start)
    );

    dtg_sync #(.CW(CW)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .refresh    (refresh),
        .blank      (blank),
        .cfg        (sync_cfg),
        .hcnt       (hcount),
        .vcnt       (vcount),
        .htot       (tim[TIM_HTOT]),
        .hact       (tim[TIM_HACT]),
        .hss        (tim[TIM_HSS]),
        .hse        (tim[TIM_HSE]),
        .vact       (tim[TIM_VACT]),
        .vss        (tim[TIM_VSS]),
        .vse        (tim[TIM_VSE]),
        .fetch_pt   (tim[TIM_FETCH]),
        .de_o       (de),
        .hsync_o    (hsync),
        .vsync_o    (vsync),
        .rgb_sync_o (rgb_sync),
        .fetch_o    (fetch)
    );

endmodule

// File: tb/test_dtg_top.sv
// Bench for dtg_top: sweeps full frames of a 12x8 raster under each
// control, sync-shaping and blanking setting. Expected values come from
// the cycle count since enable.
module test_dtg_top;

    localparam int CW = 12;
    localparam int AW = 4;
    localparam int HT = 12, VT = 8, FRAME = HT * VT;
    localparam int HSS = 6, HSE = 8, VACT = 3, VSS = 4, VSE = 6, FPT = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] hcount, vcount;
    logic          de, hsync, vsync, rgb_sync, fetch;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int e_ctrl = 0, e_sctl = 0, e_dctl = 0, e_hact = 0, e_hact_new = 0;
    int pend = 0, switch_n = 0, c_en = 0;

    dtg_top #(.CW(CW), .AW(AW)) i_dtg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hcount(hcount), .vcount(vcount), .de(de),
        .hsync(hsync), .vsync(vsync), .rgb_sync(rgb_sync), .fetch(fetch)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string sig, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, sig, act, exp, cyc);
        end
    endtask

    // Register write; the model tracks when each write becomes visible (R12, R11)
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 0) begin
            if ((d & 1) != 0 && (e_ctrl & 1) == 0) c_en = cyc;
            if ((d & 1) == 0 && pend != 0) begin e_hact = e_hact_new; pend = 0; end
            e_ctrl = d;
        end
        if (a == 1) e_sctl = d;
        if (a == 2) e_dctl = d;
        if (a == 4) begin
            if ((e_ctrl & 1) != 0) begin
                pend = 1; e_hact_new = d;
                switch_n = ((cyc - c_en) / FRAME + 1) * FRAME;
            end else begin
                e_hact = d;
            end
        end
    endtask

    task automatic sample(input string tag);
        int n, h, v, run, hs, vs, hl, vl, exp_de;
        n = cyc - c_en;
        run = e_ctrl & 1;
        if (pend != 0 && n >= switch_n) begin e_hact = e_hact_new; pend = 0; end
        h = (run != 0) ? n % HT : 0;
        v = (run != 0) ? (n / HT) % VT : 0;
        hs = (run != 0 && h > HSS && h <= HSE) ? 1 : 0;
        vs = (run != 0 && v > VSS && v <= VSE) ? 1 : 0;
        hl = (hs != 0 && (e_sctl & 'h02) == 0 && (e_sctl & 'h20) == 0) ? 1 : 0;
        vl = (vs != 0 && (e_sctl & 'h02) == 0 && (e_sctl & 'h40) == 0) ? 1 : 0;
        exp_de = (run != 0 && (e_ctrl & 2) != 0 && (e_dctl & 4) == 0
                  && h <= e_hact && v <= VACT) ? 1 : 0;
        check(tag, "R1 hcount", int'(hcount), h);
        check(tag, "R1 vcount", int'(vcount), v);
        check(tag, "R2 de", int'(de), exp_de);
        check(tag, "R3 R7 hsync", int'(hsync), hl ^ ((e_sctl >> 3) & 1));
        check(tag, "R3 R7 vsync", int'(vsync), vl ^ ((e_sctl >> 4) & 1));
        check(tag, "R4 fetch", int'(fetch), (run != 0 && h == FPT) ? 1 : 0);
        check(tag, "R9 rgb_sync", int'(rgb_sync), ((e_sctl & 1) != 0 && (hl | vl) != 0) ? 1 : 0);
    endtask

    task automatic sweep(input string tag, input int ncyc);
        repeat (ncyc) begin
            @(negedge clk);
            sample(tag);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sample("R5 reset");
        // Geometry programmed while stopped, by index (R12)
        wr(3, HT - 1); wr(4, 5); wr(5, HSS); wr(6, HSE);
        wr(7, VT - 1); wr(8, VACT); wr(9, VSS); wr(10, VSE); wr(11, FPT);
        sweep("R5 stopped", 10);
        wr(0, 3);
        sweep("R1 R2 R3 R4 base", 2 * FRAME);
        wr(1, 'h18); sweep("R7 invert", FRAME);
        wr(1, 'h20); sweep("R8 h off", FRAME);
        wr(1, 'h40); sweep("R8 v off", FRAME);
        wr(1, 'h0A); sweep("R8 all off", FRAME);
        wr(1, 'h01); sweep("R9 rgb", FRAME);
        wr(1, 'h21); sweep("R9 rgb h off", FRAME);
        wr(1, 'h00);
        wr(2, 4); sweep("R10 blank", FRAME);
        wr(2, 0);
        wr(0, 1); sweep("R6 no refresh", FRAME);
        wr(0, 3); sweep("R6 refresh back", 40);
        wr(4, 3); sweep("R11 frame start", 2 * FRAME + 20);
        wr(1, 'h18); wr(0, 0); sweep("R5 stopped inverted", 30);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule